// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds one fetch status state machine for each hardware thread of a multithreaded instruction front end. Every cycle it takes block and unblock pulses from four downstream stages, redirect requests from commit and from decode, a per-thread flag saying that the reorder buffer is still discarding work, and events from the instruction cache port. These events are a request launch with its accept or refuse answer, a tagged response and a retry. From these inputs it computes each thread's next status, its program counter pair, its line buffer, and a one-cycle cancel strobe for a cache miss that has become useless.

The decision for each thread is a priority chain. A commit redirect beats the still-discarding flag. That flag beats a decode redirect. A decode redirect beats a stall. A stall beats the release of a blocked or discarding thread. Only when none of these applies do the thread's own cache, trap and quiesce events move it. The block keeps a single retry slot for the whole cache port. While the slot is occupied the port is reported blocked, and no thread may launch a new request. A cache response whose thread is no longer waiting, or whose tag does not match that thread's outstanding request, is thrown away and counted.

States, as driven on `state_o` (4 bits per thread): Run=0, Idle=1, Squash=2, Block=3, WaitRsp=4, WaitRetry=5, Done=6, Trap=7, Quiesce=8. Transitions:
- any state to Squash: a commit redirect, the still-discarding flag, or a decode redirect.
- any state except WaitRsp and WaitRetry to Block: a stall.
- Block or Squash to Run: release.
- Run to WaitRsp: request accepted.
- Run to WaitRetry: request refused.
- Run to Trap: trap event.
- Run to Quiesce: quiesce event.
- WaitRetry to WaitRsp: retry accepted.
- WaitRsp to Done: matching response, thread not stalled.
- WaitRsp to Block: matching response, thread stalled.
- Done to Run: advance.
- Quiesce to Run: wake.

Idle is encoded but has no transition into it. It is held only until a redirect or a stall moves the thread on.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is in Run (code 0). All stall bits are clear. `pc_o` equals RESET_PC and `npc_o` equals RESET_PC+4. The port is not blocked, `active_o` is 1, `drop_cnt_o` is 0, and `cancel_o` is 0.
- R2: Each thread keeps one sticky stall bit per stage. Stage s and thread t use input bit s*NUM_THR+t of `block_i` and `unblock_i`. A block pulse sets the bit and an unblock pulse clears it; when both arrive in the same cycle, unblock wins. A thread is stalled when any of its bits is set after this cycle's update, or when `ctx_switch_i` is high. A Block or Squash thread that is not stalled, and has no redirect or still-discarding flag, returns to Run on the next edge.
- R3: A commit redirect for thread t moves the thread to Squash on the next edge, whatever its state. It sets `pc_o` to the target and `npc_o` to target+4. On the same thread in the same cycle it wins over every other input, including a decode redirect.
- R4: When there is no commit redirect, a high `rob_busy_i[t]` puts or holds thread t in Squash without changing its PC.
- R5: A decode redirect moves a thread to Squash and sets its PC pair like R3, but only if the thread is not already in Squash. If the thread is in Squash, the redirect is ignored: the PC is unchanged and the thread stays in Squash.
- R6: When no redirect or still-discarding flag applies, a stalled thread goes to Block from every state except WaitRsp and WaitRetry. Those two states keep their state.
- R7: A request (`req_vld_i` for thread `req_tid_i`) is taken only by a thread in Run whose higher-priority events did not fire, and only while the port is not blocked. While the port is blocked, the request is ignored. An accepted request (`req_ack_i`=1) moves the thread to WaitRsp and records `req_tag_i`. A refused request moves the thread to WaitRetry, stores the thread and tag in the retry slot, and raises `port_blocked_o`.
- R8: A response is accepted only when its thread is in WaitRsp, reaches the cache-event step of the chain, and carries the recorded tag. An accepted response loads `rsp_data_i` into that thread's `line_o` and moves the thread to Done, or to Block if the thread is stalled. Any other response leaves the line unchanged and increments `drop_cnt_o` by one (wrapping).
- R9: `retry_i` with `retry_ok_i`=1 while the slot is occupied empties the slot and clears `port_blocked_o`. If the slot's thread is in WaitRetry and nothing of higher priority applies, it moves to WaitRsp with the slot's tag. A retry with `retry_ok_i`=0 changes nothing.
- R10: When a redirect (commit or decode) hits a thread in WaitRsp, `cancel_o[t]` pulses for exactly the cycle after the edge. When a redirect hits the thread that owns the retry slot, the slot is emptied and `port_blocked_o` falls.
- R11: From Run, `trap_i` moves the thread to Trap; otherwise `quiesce_i` moves it to Quiesce; both win over a request. `wake_i` returns Quiesce to Run, and `advance_i` returns Done to Run.
- R12: `active_o` is 1 exactly when at least one thread is in Run, Squash or Done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| block_i | input | 4*NUM_THR | Block pulses, bit s*NUM_THR+t for stage s, thread t |
| unblock_i | input | 4*NUM_THR | Unblock pulses, same layout |
| ctx_switch_i | input | 1 | Global stall for all threads |
| cmt_sq_vld_i | input | 1 | Commit redirect valid |
| cmt_sq_tid_i | input | TID_W | Commit redirect thread |
| cmt_sq_pc_i | input | PC_W | Commit redirect target |
| dec_sq_vld_i | input | 1 | Decode redirect valid |
| dec_sq_tid_i | input | TID_W | Decode redirect thread |
| dec_sq_pc_i | input | PC_W | Decode redirect target |
| rob_busy_i | input | NUM_THR | Reorder buffer still discarding, per thread |
| req_vld_i | input | 1 | Cache request launched |
| req_tid_i | input | TID_W | Requesting thread |
| req_ack_i | input | 1 | Port accepted the request (0 = refused) |
| req_tag_i | input | TAG_W | Request tag |
| rsp_vld_i | input | 1 | Cache response valid |
| rsp_tid_i | input | TID_W | Response thread |
| rsp_tag_i | input | TAG_W | Response tag |
| rsp_data_i | input | LINE_W | Returned line |
| retry_i | input | 1 | Port retry event |
| retry_ok_i | input | 1 | Re-sent request accepted |
| advance_i | input | NUM_THR | Done thread consumed, per thread |
| trap_i | input | NUM_THR | Trap event, per thread |
| quiesce_i | input | NUM_THR | Quiesce event, per thread |
| wake_i | input | NUM_THR | Wake from quiesce, per thread |
| state_o | output | 4*NUM_THR | Per-thread state code |
| pc_o | output | PC_W*NUM_THR | Per-thread PC |
| npc_o | output | PC_W*NUM_THR | Per-thread next PC |
| line_o | output | LINE_W*NUM_THR | Per-thread line buffer |
| cancel_o | output | NUM_THR | Outstanding miss cancelled |
| port_blocked_o | output | 1 | Retry slot occupied |
| active_o | output | 1 | Stage has work |
| drop_cnt_o | output | CNT_W | Discarded responses, wrapping |

## Verification
The bench goes after the priority collisions. It sends a commit and a decode redirect to one thread in the same cycle; a design that ranks them the other way ends up with the decode target in `pc_o`. It sends a decode redirect into a thread held in Squash; a design that does not filter it moves the PC. It sends a stall while a thread waits on a response; a design that blocks a waiting thread never accepts the returning line. It also drives a response with the wrong tag, a request while the port is blocked, and a redirect of the retry slot's owner. A design that mishandles these accepts stale data, loses the slot or leaves the port blocked for good. Random traffic then mixes all events so that rare interleavings, such as a retry landing on a thread that has just left WaitRetry, are compared against the bench model.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int NSTG = 4;
    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_RUN     = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SQUASH  = 4'd2,
        ST_BLOCK   = 4'd3,
        ST_WRSP    = 4'd4,
        ST_WRTY    = 4'd5,
        ST_DONE    = 4'd6,
        ST_TRAP    = 4'd7,
        ST_QUIESCE = 4'd8
    } fst_e;
endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track #(
    parameter int NUM_THR = 4,
    parameter int NSTG    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSTG*NUM_THR-1:0] block_i,
    input  logic [NSTG*NUM_THR-1:0] unblock_i,
    input  logic                    ctx_switch_i,
    output logic [NUM_THR-1:0]      stalled_o
);
    localparam int NBITS = NSTG * NUM_THR;

    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] bits_d;

    // unblock applied after block: unblock wins a same-cycle collision (R2)
    assign bits_d = (bits_q | block_i) & ~unblock_i;

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic [NSTG-1:0] per_stage;
        for (genvar s = 0; s < NSTG; s++) begin : g_stg
            assign per_stage[s] = bits_d[s*NUM_THR + t];
        end
        assign stalled_o[t] = (|per_stage) | ctx_switch_i;
    end
endmodule

// File: rtl/fsc_retry_slot.sv
module fsc_retry_slot #(
    parameter int NUM_THR = 4,
    parameter int TAG_W   = 4,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [TID_W-1:0]   load_tid_i,
    input  logic [TAG_W-1:0]   load_tag_i,
    input  logic               retry_i,
    input  logic               retry_ok_i,
    input  logic [NUM_THR-1:0] redirect_i,
    output logic               full_o,
    output logic [TID_W-1:0]   tid_o,
    output logic [TAG_W-1:0]   tag_o
);
    logic drain;

    assign drain = full_o && ((retry_i && retry_ok_i) || redirect_i[tid_o]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            tid_o  <= '0;
            tag_o  <= '0;
        end else if (load_i) begin
            full_o <= 1'b1;
            tid_o  <= load_tid_i;
            tag_o  <= load_tag_i;
        end else if (drain) begin
            full_o <= 1'b0;
        end
    end

    // only one retry may be held: a refusal can never land on a full slot
    p_single_slot_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !full_o);

    // an accepted retry always frees the port (R9)
    p_retry_frees_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && retry_i && retry_ok_i) |=> !full_o);
endmodule

// File: rtl/fsc_thread.sv
module fsc_thread
    import fsc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              TAG_W    = 4,
    parameter int              LINE_W   = 64,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stalled_i,
    input  logic              cmt_sq_i,
    input  logic [PC_W-1:0]   cmt_pc_i,
    input  logic              rob_busy_i,
    input  logic              dec_sq_i,
    input  logic [PC_W-1:0]   dec_pc_i,
    input  logic              req_i,
    input  logic              req_ack_i,
    input  logic [TAG_W-1:0]  req_tag_i,
    input  logic              rsp_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic [LINE_W-1:0] rsp_data_i,
    input  logic              retry_fire_i,
    input  logic [TAG_W-1:0]  slot_tag_i,
    input  logic              advance_i,
    input  logic              trap_i,
    input  logic              quiesce_i,
    input  logic              wake_i,
    output fst_e              state_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   npc_o,
    output logic [LINE_W-1:0] line_o,
    output logic              cancel_o,
    output logic              redirect_o,
    output logic              refuse_o,
    output logic              rsp_ok_o
);
    fst_e             st_d;
    logic [PC_W-1:0]  target;
    logic             set_tag;
    logic [TAG_W-1:0] new_tag;
    logic [TAG_W-1:0] otag_q;

    // next-state priority chain
    always_comb begin
        st_d       = state_o;
        redirect_o = 1'b0;
        target     = cmt_pc_i;
        refuse_o   = 1'b0;
        rsp_ok_o   = 1'b0;
        set_tag    = 1'b0;
        new_tag    = req_tag_i;
        if (cmt_sq_i) begin
            st_d       = ST_SQUASH;
            redirect_o = 1'b1;
        end else if (rob_busy_i) begin
            st_d = ST_SQUASH;
        end else if (dec_sq_i) begin
            if (state_o != ST_SQUASH) begin
                st_d       = ST_SQUASH;
                redirect_o = 1'b1;
                target     = dec_pc_i;
            end
        end else if (stalled_i && state_o != ST_WRSP && state_o != ST_WRTY) begin
            st_d = ST_BLOCK;
        end else if (state_o == ST_BLOCK || state_o == ST_SQUASH) begin
            st_d = ST_RUN;
        end else begin
            unique case (state_o)
                ST_RUN: begin
                    if (trap_i) begin
                        st_d = ST_TRAP;
                    end else if (quiesce_i) begin
                        st_d = ST_QUIESCE;
                    end else if (req_i) begin
                        if (req_ack_i) begin
                            st_d    = ST_WRSP;
                            set_tag = 1'b1;
                        end else begin
                            st_d     = ST_WRTY;
                            refuse_o = 1'b1;
                        end
                    end
                end
                ST_WRSP: begin
                    if (rsp_i && rsp_tag_i == otag_q) begin
                        rsp_ok_o = 1'b1;
                        st_d     = stalled_i ? ST_BLOCK : ST_DONE;
                    end
                end
                ST_WRTY: begin
                    if (retry_fire_i) begin
                        st_d    = ST_WRSP;
                        set_tag = 1'b1;
                        new_tag = slot_tag_i;
                    end
                end
                ST_DONE:    if (advance_i) st_d = ST_RUN;
                ST_QUIESCE: if (wake_i)    st_d = ST_RUN;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_RUN;
        else        state_o <= st_d;
    end

    // outputs and per-thread data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o     <= RESET_PC;
            npc_o    <= RESET_PC + PC_W'(4);
            line_o   <= '0;
            cancel_o <= 1'b0;
            otag_q   <= '0;
        end else begin
            cancel_o <= redirect_o && (state_o == ST_WRSP);
            if (redirect_o) begin
                pc_o  <= target;
                npc_o <= target + PC_W'(4);
            end
            if (rsp_ok_o) line_o <= rsp_data_i;
            if (set_tag)  otag_q <= new_tag;
        end
    end

    // commit redirect wins over everything (R3)
    p_commit_wins_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        cmt_sq_i |=> (state_o == ST_SQUASH) && (pc_o == $past(cmt_pc_i)));

    // still-discarding flag holds the thread in Squash (R4)
    p_rob_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rob_busy_i && !cmt_sq_i) |=> state_o == ST_SQUASH);

    // stall blocks every state but the two cache waits (R6)
    p_stall_block_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_sq_i && !rob_busy_i && !dec_sq_i && stalled_i &&
         state_o != ST_WRSP && state_o != ST_WRTY) |=> state_o == ST_BLOCK);
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int              NUM_THR  = 4,
    parameter int              PC_W     = 32,
    parameter int              TAG_W    = 4,
    parameter int              LINE_W   = 64,
    parameter int              CNT_W    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int             TID_W    = $clog2(NUM_THR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSTG*NUM_THR-1:0]  block_i,
    input  logic [NSTG*NUM_THR-1:0]  unblock_i,
    input  logic                     ctx_switch_i,
    input  logic                     cmt_sq_vld_i,
    input  logic [TID_W-1:0]         cmt_sq_tid_i,
    input  logic [PC_W-1:0]          cmt_sq_pc_i,
    input  logic                     dec_sq_vld_i,
    input  logic [TID_W-1:0]         dec_sq_tid_i,
    input  logic [PC_W-1:0]          dec_sq_pc_i,
    input  logic [NUM_THR-1:0]       rob_busy_i,
    input  logic                     req_vld_i,
    input  logic [TID_W-1:0]         req_tid_i,
    input  logic                     req_ack_i,
    input  logic [TAG_W-1:0]         req_tag_i,
    input  logic                     rsp_vld_i,
    input  logic [TID_W-1:0]         rsp_tid_i,
    input  logic [TAG_W-1:0]         rsp_tag_i,
    input  logic [LINE_W-1:0]        rsp_data_i,
    input  logic                     retry_i,
    input  logic                     retry_ok_i,
    input  logic [NUM_THR-1:0]       advance_i,
    input  logic [NUM_THR-1:0]       trap_i,
    input  logic [NUM_THR-1:0]       quiesce_i,
    input  logic [NUM_THR-1:0]       wake_i,
    output logic [ST_W*NUM_THR-1:0]  state_o,
    output logic [PC_W*NUM_THR-1:0]  pc_o,
    output logic [PC_W*NUM_THR-1:0]  npc_o,
    output logic [LINE_W*NUM_THR-1:0] line_o,
    output logic [NUM_THR-1:0]       cancel_o,
    output logic                     port_blocked_o,
    output logic                     active_o,
    output logic [CNT_W-1:0]         drop_cnt_o
);
    logic [NUM_THR-1:0] stalled;
    logic [NUM_THR-1:0] redirect_vec;
    logic [NUM_THR-1:0] refuse_vec;
    logic [NUM_THR-1:0] rsp_ok_vec;
    logic [NUM_THR-1:0] busy_vec;
    fst_e               st_vec [NUM_THR];
    logic               slot_full;
    logic [TID_W-1:0]   slot_tid;
    logic [TAG_W-1:0]   slot_tag;
    logic [TID_W-1:0]   load_tid;
    logic               drop_evt;

    fsc_stall_track #(.NUM_THR(NUM_THR), .NSTG(NSTG)) u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .block_i      (block_i),
        .unblock_i    (unblock_i),
        .ctx_switch_i (ctx_switch_i),
        .stalled_o    (stalled)
    );

    always_comb begin
        load_tid = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (refuse_vec[i]) load_tid = TID_W'(i);
        end
    end

    fsc_retry_slot #(.NUM_THR(NUM_THR), .TAG_W(TAG_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (|refuse_vec),
        .load_tid_i (load_tid),
        .load_tag_i (req_tag_i),
        .retry_i    (retry_i),
        .retry_ok_i (retry_ok_i),
        .redirect_i (redirect_vec),
        .full_o     (slot_full),
        .tid_o      (slot_tid),
        .tag_o      (slot_tag)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic mine_cmt, mine_dec, mine_req, mine_rsp, mine_retry;

        assign mine_cmt   = cmt_sq_vld_i && (cmt_sq_tid_i == TID_W'(t));
        assign mine_dec   = dec_sq_vld_i && (dec_sq_tid_i == TID_W'(t));
        assign mine_req   = req_vld_i && (req_tid_i == TID_W'(t)) && !slot_full;
        assign mine_rsp   = rsp_vld_i && (rsp_tid_i == TID_W'(t));
        assign mine_retry = retry_i && retry_ok_i && slot_full && (slot_tid == TID_W'(t));

        fsc_thread #(
            .PC_W(PC_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .RESET_PC(RESET_PC)
        ) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .stalled_i    (stalled[t]),
            .cmt_sq_i     (mine_cmt),
            .cmt_pc_i     (cmt_sq_pc_i),
            .rob_busy_i   (rob_busy_i[t]),
            .dec_sq_i     (mine_dec),
            .dec_pc_i     (dec_sq_pc_i),
            .req_i        (mine_req),
            .req_ack_i    (req_ack_i),
            .req_tag_i    (req_tag_i),
            .rsp_i        (mine_rsp),
            .rsp_tag_i    (rsp_tag_i),
            .rsp_data_i   (rsp_data_i),
            .retry_fire_i (mine_retry),
            .slot_tag_i   (slot_tag),
            .advance_i    (advance_i[t]),
            .trap_i       (trap_i[t]),
            .quiesce_i    (quiesce_i[t]),
            .wake_i       (wake_i[t]),
            .state_o      (st_vec[t]),
            .pc_o         (pc_o[t*PC_W +: PC_W]),
            .npc_o        (npc_o[t*PC_W +: PC_W]),
            .line_o       (line_o[t*LINE_W +: LINE_W]),
            .cancel_o     (cancel_o[t]),
            .redirect_o   (redirect_vec[t]),
            .refuse_o     (refuse_vec[t]),
            .rsp_ok_o     (rsp_ok_vec[t])
        );

        assign state_o[t*ST_W +: ST_W] = st_vec[t];
        assign busy_vec[t] = (st_vec[t] == ST_RUN) || (st_vec[t] == ST_SQUASH) ||
                             (st_vec[t] == ST_DONE);

        // a cancel strobe only follows a thread that was waiting on a response (R10)
        p_cancel_src_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            cancel_o[t] |-> $past(st_vec[t]) == ST_WRSP);
    end

    assign active_o       = |busy_vec;
    assign port_blocked_o = slot_full;
    assign drop_evt       = rsp_vld_i && !rsp_ok_vec[rsp_tid_i];

    always_ff @(posedge clk) begin
        if (!rst_n)        drop_cnt_o <= '0;
        else if (drop_evt) drop_cnt_o <= drop_cnt_o + CNT_W'(1);
    end

    // a request offered to a blocked port never clears the block by itself (R7)
    p_blocked_ignore_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full && req_vld_i && !retry_i && !(|redirect_vec)) |=> port_blocked_o);

    // at most one thread can be refused per cycle
    p_one_refusal_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(refuse_vec));
endmodule

// File: tb/test_fetch_status_ctrl.sv
`timescale 1ns/1ps
module test_fetch_status_ctrl;
    localparam int NT = 4;
    localparam int PW = 32;
    localparam int TW = 4;
    localparam int LW = 64;
    localparam int CW = 8;
    localparam int NS = 4;
    localparam int S_RUN = 0, S_IDLE = 1, S_SQ = 2, S_BLK = 3, S_WRSP = 4,
                   S_WRTY = 5, S_DONE = 6, S_TRAP = 7, S_QUI = 8;

    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic [NS*NT-1:0] blk, unblk;
    logic ctx, cmt_v, dec_v, req_v, req_acc, rsp_v, rty, rty_ok;
    logic [1:0] cmt_tid, dec_tid, req_tid, rsp_tid;
    logic [PW-1:0] cmt_pc, dec_pc;
    logic [NT-1:0] rob, adv, trap, qui, wake;
    logic [TW-1:0] req_tag, rsp_tag;
    logic [LW-1:0] rsp_data;

    logic [4*NT-1:0]  state_o;
    logic [PW*NT-1:0] pc_o, npc_o;
    logic [LW*NT-1:0] line_o;
    logic [NT-1:0]    cancel_o;
    logic             port_blocked_o, active_o;
    logic [CW-1:0]    drop_cnt_o;

    fetch_status_ctrl i_fetch_status_ctrl (
        .clk(clk), .rst_n(rst_n), .block_i(blk), .unblock_i(unblk),
        .ctx_switch_i(ctx), .cmt_sq_vld_i(cmt_v), .cmt_sq_tid_i(cmt_tid),
        .cmt_sq_pc_i(cmt_pc), .dec_sq_vld_i(dec_v), .dec_sq_tid_i(dec_tid),
        .dec_sq_pc_i(dec_pc), .rob_busy_i(rob), .req_vld_i(req_v),
        .req_tid_i(req_tid), .req_ack_i(req_acc), .req_tag_i(req_tag),
        .rsp_vld_i(rsp_v), .rsp_tid_i(rsp_tid), .rsp_tag_i(rsp_tag),
        .rsp_data_i(rsp_data), .retry_i(rty), .retry_ok_i(rty_ok),
        .advance_i(adv), .trap_i(trap), .quiesce_i(qui), .wake_i(wake),
        .state_o(state_o), .pc_o(pc_o), .npc_o(npc_o), .line_o(line_o),
        .cancel_o(cancel_o), .port_blocked_o(port_blocked_o),
        .active_o(active_o), .drop_cnt_o(drop_cnt_o)
    );

    // bench model
    int            m_st [NT];
    logic [PW-1:0] m_pc [NT];
    logic [PW-1:0] m_npc[NT];
    logic [LW-1:0] m_line[NT];
    logic [TW-1:0] m_otag[NT];
    logic          m_cancel[NT];
    logic [NS*NT-1:0] m_stall;
    logic          m_full;
    int            m_stid;
    logic [TW-1:0] m_stag;
    logic [CW-1:0] m_drop;
    string         why[NT];
    string         slot_why;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_busy(input int s);
        return s == S_RUN || s == S_SQ || s == S_DONE;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = S_RUN; m_pc[t] = '0; m_npc[t] = 32'd4;
            m_line[t] = '0; m_otag[t] = '0; m_cancel[t] = 0; why[t] = "R1";
        end
        m_stall = '0; m_full = 0; m_stid = 0; m_stag = '0; m_drop = '0;
        slot_why = "R1";
    endtask

    task automatic model_step();
        logic [NS*NT-1:0] ns;
        logic stl;
        bit cs, ds, redir, acc, fire_clear, sq_clear, load;
        int n;
        logic [PW-1:0] tgt;
        logic [TW-1:0] ltag;
        int ltid;
        int old_st[NT];
        ns = (m_stall | blk) & ~unblk;
        fire_clear = m_full && rty && rty_ok;
        sq_clear = 0; load = 0; ltid = 0; ltag = req_tag;
        for (int t = 0; t < NT; t++) old_st[t] = m_st[t];
        for (int t = 0; t < NT; t++) begin
            stl = ctx;
            for (int s = 0; s < NS; s++) stl = stl | ns[s*NT+t];
            cs = cmt_v && cmt_tid == t;
            ds = dec_v && dec_tid == t;
            n = old_st[t]; redir = 0; acc = 0; tgt = cmt_pc;
            why[t] = "R2";
            if (cs) begin n = S_SQ; redir = 1; why[t] = "R3"; end
            else if (rob[t]) begin n = S_SQ; why[t] = "R4"; end
            else if (ds) begin
                why[t] = "R5";
                if (old_st[t] != S_SQ) begin n = S_SQ; redir = 1; tgt = dec_pc; end
            end
            else if (stl && old_st[t] != S_WRSP && old_st[t] != S_WRTY) begin
                n = S_BLK; why[t] = "R6";
            end
            else if (old_st[t] == S_BLK || old_st[t] == S_SQ) begin
                n = S_RUN; why[t] = "R2";
            end
            else begin
                case (old_st[t])
                    S_RUN: begin
                        if (trap[t]) begin n = S_TRAP; why[t] = "R11"; end
                        else if (qui[t]) begin n = S_QUI; why[t] = "R11"; end
                        else if (req_v && req_tid == t && !m_full) begin
                            why[t] = "R7";
                            if (req_acc) begin n = S_WRSP; m_otag[t] = req_tag; end
                            else begin n = S_WRTY; load = 1; ltid = t; end
                        end
                    end
                    S_WRSP: if (rsp_v && rsp_tid == t && rsp_tag == m_otag[t]) begin
                        acc = 1; n = stl ? S_BLK : S_DONE; why[t] = "R8";
                    end
                    S_WRTY: if (fire_clear && m_stid == t) begin
                        n = S_WRSP; m_otag[t] = m_stag; why[t] = "R9";
                    end
                    S_DONE: if (adv[t]) begin n = S_RUN; why[t] = "R11"; end
                    S_QUI:  if (wake[t]) begin n = S_RUN; why[t] = "R11"; end
                    default: ;
                endcase
            end
            m_cancel[t] = redir && old_st[t] == S_WRSP;
            if (redir) begin
                m_pc[t] = tgt; m_npc[t] = tgt + 32'd4;
                if (m_full && m_stid == t) sq_clear = 1;
            end
            if (acc) m_line[t] = rsp_data;
            if (rsp_v && rsp_tid == t && !acc) m_drop = m_drop + 8'd1;
            m_st[t] = n;
        end
        if (load) begin
            m_full = 1; m_stid = ltid; m_stag = ltag; slot_why = "R7";
        end else if (fire_clear) begin
            m_full = 0; slot_why = "R9";
        end else if (sq_clear) begin
            m_full = 0; slot_why = "R10";
        end
        m_stall = ns;
    endtask

    task automatic check_all();
        bit any;
        any = 0;
        for (int t = 0; t < NT; t++) begin
            chk(why[t], $sformatf("state[%0d]", t), 64'(state_o[t*4 +: 4]), 64'(m_st[t]));
            chk(why[t], $sformatf("pc[%0d]", t), 64'(pc_o[t*PW +: PW]), 64'(m_pc[t]));
            chk(why[t], $sformatf("npc[%0d]", t), 64'(npc_o[t*PW +: PW]), 64'(m_npc[t]));
            chk("R8", $sformatf("line[%0d]", t), line_o[t*LW +: LW], m_line[t]);
            chk("R10", $sformatf("cancel[%0d]", t), 64'(cancel_o[t]), 64'(m_cancel[t]));
            any = any | is_busy(m_st[t]);
        end
        chk(slot_why, "port_blocked", 64'(port_blocked_o), 64'(m_full));
        chk("R12", "active", 64'(active_o), 64'(any));
        chk("R8", "drop_cnt", 64'(drop_cnt_o), 64'(m_drop));
    endtask

    task automatic clr();
        blk = '0; unblk = '0; ctx = 0; cmt_v = 0; dec_v = 0; rob = '0;
        req_v = 0; req_acc = 0; rsp_v = 0; rty = 0; rty_ok = 0;
        adv = '0; trap = '0; qui = '0; wake = '0;
        cmt_tid = 0; dec_tid = 0; req_tid = 0; rsp_tid = 0;
        cmt_pc = '0; dec_pc = '0; req_tag = '0; rsp_tag = '0; rsp_data = '0;
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        check_all();
        clr();
    endtask

    initial begin
        clr();
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check_all();

        // R3 R5: commit and decode redirect on one thread in one cycle
        cmt_v = 1; cmt_tid = 0; cmt_pc = 32'h100;
        dec_v = 1; dec_tid = 0; dec_pc = 32'h200; cyc();
        cyc();
        // R4 R5: decode redirect while held in Squash is ignored
        rob[1] = 1; cyc();
        dec_v = 1; dec_tid = 1; dec_pc = 32'h300; cyc();
        cyc();
        // R7 R9: refusal, blocked-port request ignored, retry
        req_v = 1; req_tid = 2; req_acc = 0; req_tag = 4'h5; cyc();
        req_v = 1; req_tid = 3; req_acc = 1; req_tag = 4'h6; cyc();
        rty = 1; rty_ok = 0; cyc();
        rty = 1; rty_ok = 1; cyc();
        // R8: wrong tag dropped, stall while waiting, right tag while stalled
        rsp_v = 1; rsp_tid = 2; rsp_tag = 4'h4; rsp_data = 64'hDEAD; cyc();
        blk[1*NT+2] = 1; cyc();
        rsp_v = 1; rsp_tid = 2; rsp_tag = 4'h5; rsp_data = 64'hBEEF_0001; cyc();
        unblk[1*NT+2] = 1; cyc();
        // R10: redirect of a waiting thread
        req_v = 1; req_tid = 0; req_acc = 1; req_tag = 4'h9; cyc();
        cmt_v = 1; cmt_tid = 0; cmt_pc = 32'h400; cyc();
        cyc();
        // R10: redirect of the retry slot owner
        req_v = 1; req_tid = 1; req_acc = 0; req_tag = 4'h3; cyc();
        dec_v = 1; dec_tid = 1; dec_pc = 32'h500; cyc();
        cyc();
        // R11: trap, quiesce, wake, advance
        trap[3] = 1; cyc();
        cyc();
        qui[2] = 1; cyc();
        wake[2] = 1; cyc();
        req_v = 1; req_tid = 0; req_acc = 1; req_tag = 4'h1; cyc();
        rsp_v = 1; rsp_tid = 0; rsp_tag = 4'h1; rsp_data = 64'h1234; cyc();
        adv[0] = 1; cyc();
        cmt_v = 1; cmt_tid = 3; cmt_pc = 32'h600; cyc();
        cyc();
        // R2 R6: global stall then release, block/unblock collision
        ctx = 1; cyc();
        ctx = 0; cyc();
        blk[3*NT+1] = 1; unblk[3*NT+1] = 1; cyc();

        // constrained random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < NS*NT; b++) begin
                blk[b]   = ($urandom % 40) == 0;
                unblk[b] = ($urandom % 8) == 0;
            end
            ctx     = ($urandom % 30) == 0;
            cmt_v   = ($urandom % 20) == 0;
            cmt_tid = 2'($urandom);
            cmt_pc  = {$urandom} & 32'hFFFF_FFFC;
            dec_v   = ($urandom % 12) == 0;
            dec_tid = 2'($urandom);
            dec_pc  = {$urandom} & 32'hFFFF_FFFC;
            for (int t = 0; t < NT; t++) begin
                rob[t]  = ($urandom % 25) == 0;
                adv[t]  = ($urandom % 2) == 0;
                trap[t] = ($urandom % 60) == 0;
                qui[t]  = ($urandom % 60) == 0;
                wake[t] = ($urandom % 8) == 0;
            end
            req_v   = ($urandom % 3) == 0;
            req_tid = 2'($urandom);
            req_acc = ($urandom % 4) != 0;
            req_tag = 4'($urandom);
            rsp_v   = ($urandom % 3) == 0;
            rsp_tid = 2'($urandom);
            rsp_tag = (($urandom % 2) == 0) ? m_otag[rsp_tid] : 4'($urandom);
            rsp_data = {$urandom, $urandom};
            rty     = ($urandom % 4) == 0;
            rty_ok  = ($urandom % 2) == 0;
            cyc();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule